// File: doc/BRIEF.md
# Multi-phase DRAM command injector

This block sits on the command path between a DRAM memory controller and its PHY. In normal operation it forwards the controller's multi-phase command bus to the PHY unchanged. When software clears the ownership bit in the control register, the controller is shut out. The PHY then sees only commands that software injects, along with clock-enable, on-die-termination and reset levels taken straight from the control register. This mode is used for power-up sequencing, mode-register loads, calibration commands and raw memory tests.

Each phase of the bus has its own set of registers: a command word, a row/column address, a bank address, a write-data word, a read-capture word and an issue strobe. Software loads the command word and its operands, then writes 1 to the phase's issue strobe. The command then appears on that phase for exactly one cycle. A command can carry a write-data flag, which presents the write-data register on that phase. It can also carry a read flag, which arms a one-time capture of the PHY's returned data into that phase's read-capture register. Two extra strobes issue the command held by the parameter-selected read phase or write phase, so software does not need to know which phase index those are.

The register port is a plain single-cycle write strobe with a combinational read. The command interface has no back-pressure: a command is presented for one cycle and the PHY must take it in that cycle.

Top module: `dram_cmd_inject`

## Requirements
- R1: After reset the control register reads 0: software owns the bus, `dfi_cke`=0, `dfi_odt`=0, `dfi_reset_n`=0, and no phase carries a command (all active-low command pins are 1, both data enables are 0).
- R2: The control register is at address 0x00. Bit0 selects the owner (1 = controller, 0 = software). While bit0 is 0, bit1 drives `dfi_cke`, bit2 drives `dfi_odt` and bit3 drives `dfi_reset_n` directly, from the cycle after the write.
- R3: The command word at phase offset 0 is active-high: bit0 chip select, bit1 write enable, bit2 CAS, bit3 RAS, bit4 write-data flag, bit5 read flag. A write with wdata bit0 = 1 to the phase's issue offset 1 happens at clock edge t. The phase then shows the inverted bits 0..3 on `dfi_cs_n/we_n/cas_n/ras_n`, plus its address and bank registers, during the cycle that follows edge t.
- R4: An injected command lasts exactly one cycle. Whenever software owns the bus, a phase with no issue strobe on the previous edge shows no command.
- R5: If bit4 is set, `dfi_wrdata_en` of that phase is 1 in the same cycle as the command, and `dfi_wrdata` carries the phase's write-data register.
- R6: If bit5 is set, `dfi_rddata_en` of that phase is 1 with the command. The first later cycle with that phase's `phy_rddata_valid` high stores `phy_rddata` into the phase's read-capture register. Later valid cycles leave the register unchanged until a new read is issued.
- R7: While bit0 of the control register is 1, every `dfi_*` output equals the matching `ctl_*` input, including clock enable, termination and reset.
- R8: An issue strobe written while bit0 is 1 is ignored: it produces no command and does not arm a read capture.
- R9: Writing 1 to address 0x01 issues the command of phase RD_PHASE. Writing 1 to address 0x02 issues the command of phase WR_PHASE.
- R10: Phase p owns addresses 0x10+8p to 0x17+8p, at these offsets: 0 command, 1 issue, 2 address, 3 bank, 4 write data, 5 read capture (read-only). Offsets 0, 2, 3 and 4 read back the last value written, zero-extended, and offset 5 reads the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational from reg_addr) |
| ctl_cs_n | input | NP | Controller chip select per phase |
| ctl_we_n | input | NP | Controller write enable per phase |
| ctl_cas_n | input | NP | Controller CAS per phase |
| ctl_ras_n | input | NP | Controller RAS per phase |
| ctl_address | input | NP*ADDR_W | Controller address per phase |
| ctl_bank | input | NP*BANK_W | Controller bank per phase |
| ctl_wrdata | input | NP*DATA_W | Controller write data per phase |
| ctl_wrdata_en | input | NP | Controller write-data enable per phase |
| ctl_rddata_en | input | NP | Controller read enable per phase |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_odt | input | 1 | Controller termination enable |
| ctl_reset_n | input | 1 | Controller memory reset, active low |
| dfi_cs_n | output | NP | Chip select to PHY |
| dfi_we_n | output | NP | Write enable to PHY |
| dfi_cas_n | output | NP | CAS to PHY |
| dfi_ras_n | output | NP | RAS to PHY |
| dfi_address | output | NP*ADDR_W | Address to PHY |
| dfi_bank | output | NP*BANK_W | Bank to PHY |
| dfi_wrdata | output | NP*DATA_W | Write data to PHY |
| dfi_wrdata_en | output | NP | Write-data enable to PHY |
| dfi_rddata_en | output | NP | Read enable to PHY |
| dfi_cke | output | 1 | Clock enable to PHY |
| dfi_odt | output | 1 | Termination enable to PHY |
| dfi_reset_n | output | 1 | Memory reset to PHY, active low |
| phy_rddata | input | NP*DATA_W | Read data from PHY per phase |
| phy_rddata_valid | input | NP | Read data valid from PHY per phase |

## Verification
The hardest case to reach is an issue strobe ignored while the controller owns the bus. Any pulse it caused would be hidden behind the forwarded controller signals. The bench therefore loads a command with the read flag while the controller owns the bus, issues it, and drives valid PHY read data on that phase. It then hands the bus back to software and reads the capture register, which must still hold its earlier contents. The command monitor meanwhile stays armed and reports any stray command. A second subtle case is a stale valid cycle arriving after a capture has already completed, which must not overwrite the stored word.

// File: rtl/dci_pkg.sv
package dci_pkg;
  localparam int CMD_W = 6;

  // bit0 cs, bit1 we, bit2 cas, bit3 ras, bit4 wr-data flag, bit5 rd flag
  typedef struct packed {
    logic rd_cap;
    logic wr_en;
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_t;

  // global register addresses
  localparam logic [7:0] ADR_CTRL     = 8'h00;
  localparam logic [7:0] ADR_RD_ISSUE = 8'h01;
  localparam logic [7:0] ADR_WR_ISSUE = 8'h02;

  // per-phase offsets inside an 8-word window starting at 0x10
  localparam logic [2:0] OFF_CMD   = 3'd0;
  localparam logic [2:0] OFF_ISSUE = 3'd1;
  localparam logic [2:0] OFF_ADDR  = 3'd2;
  localparam logic [2:0] OFF_BANK  = 3'd3;
  localparam logic [2:0] OFF_WDATA = 3'd4;
  localparam logic [2:0] OFF_RDATA = 3'd5;
endpackage

// File: rtl/dci_phase.sv
module dci_phase
  import dci_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_cmd,
  input  logic              wr_addr,
  input  logic              wr_bank,
  input  logic              wr_data,
  input  logic              issue,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0] phy_rddata,
  input  logic              phy_rdvalid,
  output cmd_t              cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [DATA_W-1:0] wrdata_q,
  output logic [DATA_W-1:0] rddata_q,
  output logic              pulse_q,
  output logic              inj_cs_n,
  output logic              inj_we_n,
  output logic              inj_cas_n,
  output logic              inj_ras_n,
  output logic              inj_wren,
  output logic              inj_rden
);
  logic fire;
  logic armed_q;

  // a strobe counts only while software owns the bus
  assign fire = issue && !sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      bank_q   <= '0;
      wrdata_q <= '0;
    end else begin
      if (wr_cmd)  cmd_q    <= cmd_t'(reg_wdata[CMD_W-1:0]);
      if (wr_addr) addr_q   <= reg_wdata[ADDR_W-1:0];
      if (wr_bank) bank_q   <= reg_wdata[BANK_W-1:0];
      if (wr_data) wrdata_q <= reg_wdata[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      armed_q  <= 1'b0;
      rddata_q <= '0;
    end else begin
      pulse_q <= fire;
      if (fire && cmd_q.rd_cap) begin
        armed_q <= 1'b1;
      end else if (armed_q && phy_rdvalid) begin
        rddata_q <= phy_rddata;
        armed_q  <= 1'b0;
      end
    end
  end

  assign inj_cs_n  = ~(pulse_q & cmd_q.cs);
  assign inj_we_n  = ~(pulse_q & cmd_q.we);
  assign inj_cas_n = ~(pulse_q & cmd_q.cas);
  assign inj_ras_n = ~(pulse_q & cmd_q.ras);
  assign inj_wren  = pulse_q & cmd_q.wr_en;
  assign inj_rden  = pulse_q & cmd_q.rd_cap;
endmodule

// File: rtl/dci_mux.sv
module dci_mux #(
  parameter int NP     = 4,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                 sel,
  input  logic [3:1]           ctrl_pins,
  input  logic [NP-1:0]        ctl_cs_n,
  input  logic [NP-1:0]        ctl_we_n,
  input  logic [NP-1:0]        ctl_cas_n,
  input  logic [NP-1:0]        ctl_ras_n,
  input  logic [NP*ADDR_W-1:0] ctl_address,
  input  logic [NP*BANK_W-1:0] ctl_bank,
  input  logic [NP*DATA_W-1:0] ctl_wrdata,
  input  logic [NP-1:0]        ctl_wrdata_en,
  input  logic [NP-1:0]        ctl_rddata_en,
  input  logic                 ctl_cke,
  input  logic                 ctl_odt,
  input  logic                 ctl_reset_n,
  input  logic [NP-1:0]        inj_cs_n,
  input  logic [NP-1:0]        inj_we_n,
  input  logic [NP-1:0]        inj_cas_n,
  input  logic [NP-1:0]        inj_ras_n,
  input  logic [NP*ADDR_W-1:0] inj_address,
  input  logic [NP*BANK_W-1:0] inj_bank,
  input  logic [NP*DATA_W-1:0] inj_wrdata,
  input  logic [NP-1:0]        inj_wrdata_en,
  input  logic [NP-1:0]        inj_rddata_en,
  output logic [NP-1:0]        dfi_cs_n,
  output logic [NP-1:0]        dfi_we_n,
  output logic [NP-1:0]        dfi_cas_n,
  output logic [NP-1:0]        dfi_ras_n,
  output logic [NP*ADDR_W-1:0] dfi_address,
  output logic [NP*BANK_W-1:0] dfi_bank,
  output logic [NP*DATA_W-1:0] dfi_wrdata,
  output logic [NP-1:0]        dfi_wrdata_en,
  output logic [NP-1:0]        dfi_rddata_en,
  output logic                 dfi_cke,
  output logic                 dfi_odt,
  output logic                 dfi_reset_n
);
  assign dfi_cs_n      = sel ? ctl_cs_n      : inj_cs_n;
  assign dfi_we_n      = sel ? ctl_we_n      : inj_we_n;
  assign dfi_cas_n     = sel ? ctl_cas_n     : inj_cas_n;
  assign dfi_ras_n     = sel ? ctl_ras_n     : inj_ras_n;
  assign dfi_address   = sel ? ctl_address   : inj_address;
  assign dfi_bank      = sel ? ctl_bank      : inj_bank;
  assign dfi_wrdata    = sel ? ctl_wrdata    : inj_wrdata;
  assign dfi_wrdata_en = sel ? ctl_wrdata_en : inj_wrdata_en;
  assign dfi_rddata_en = sel ? ctl_rddata_en : inj_rddata_en;
  assign dfi_cke       = sel ? ctl_cke       : ctrl_pins[1];
  assign dfi_odt       = sel ? ctl_odt       : ctrl_pins[2];
  assign dfi_reset_n   = sel ? ctl_reset_n   : ctrl_pins[3];
endmodule

// File: rtl/dram_cmd_inject.sv
module dram_cmd_inject
  import dci_pkg::*;
#(
  parameter int NP       = 4,
  parameter int ADDR_W   = 14,
  parameter int BANK_W   = 3,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 32,
  parameter int REG_AW   = 8,
  parameter int RD_PHASE = 2,
  parameter int WR_PHASE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NP-1:0]        ctl_cs_n,
  input  logic [NP-1:0]        ctl_we_n,
  input  logic [NP-1:0]        ctl_cas_n,
  input  logic [NP-1:0]        ctl_ras_n,
  input  logic [NP*ADDR_W-1:0] ctl_address,
  input  logic [NP*BANK_W-1:0] ctl_bank,
  input  logic [NP*DATA_W-1:0] ctl_wrdata,
  input  logic [NP-1:0]        ctl_wrdata_en,
  input  logic [NP-1:0]        ctl_rddata_en,
  input  logic                 ctl_cke,
  input  logic                 ctl_odt,
  input  logic                 ctl_reset_n,
  output logic [NP-1:0]        dfi_cs_n,
  output logic [NP-1:0]        dfi_we_n,
  output logic [NP-1:0]        dfi_cas_n,
  output logic [NP-1:0]        dfi_ras_n,
  output logic [NP*ADDR_W-1:0] dfi_address,
  output logic [NP*BANK_W-1:0] dfi_bank,
  output logic [NP*DATA_W-1:0] dfi_wrdata,
  output logic [NP-1:0]        dfi_wrdata_en,
  output logic [NP-1:0]        dfi_rddata_en,
  output logic                 dfi_cke,
  output logic                 dfi_odt,
  output logic                 dfi_reset_n,
  input  logic [NP*DATA_W-1:0] phy_rddata,
  input  logic [NP-1:0]        phy_rddata_valid
);
  localparam int PHW = REG_AW - 3;

  logic [3:0] ctrl_q;
  logic       rd_alias, wr_alias;

  logic [NP-1:0]        issue_vec, pulse_vec;
  logic [NP-1:0]        inj_cs_n, inj_we_n, inj_cas_n, inj_ras_n;
  logic [NP-1:0]        inj_wren, inj_rden;
  logic [NP*ADDR_W-1:0] inj_address;
  logic [NP*BANK_W-1:0] inj_bank;
  logic [NP*DATA_W-1:0] inj_wrdata;

  cmd_t              cmd_q    [NP];
  logic [ADDR_W-1:0] addr_q   [NP];
  logic [BANK_W-1:0] bank_q   [NP];
  logic [DATA_W-1:0] wrdata_q [NP];
  logic [DATA_W-1:0] rddata_q [NP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADR_CTRL)   ctrl_q <= reg_wdata[3:0];
  end

  assign rd_alias = reg_wr && reg_addr == ADR_RD_ISSUE && reg_wdata[0];
  assign wr_alias = reg_wr && reg_addr == ADR_WR_ISSUE && reg_wdata[0];

  for (genvar p = 0; p < NP; p++) begin : g_ph
    logic hit;
    assign hit = reg_wr && (reg_addr[REG_AW-1:3] == PHW'(p + 2));
    assign issue_vec[p] = (hit && reg_addr[2:0] == OFF_ISSUE && reg_wdata[0])
                        || (p == RD_PHASE && rd_alias)
                        || (p == WR_PHASE && wr_alias);

    dci_phase #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (ctrl_q[0]),
      .wr_cmd     (hit && reg_addr[2:0] == OFF_CMD),
      .wr_addr    (hit && reg_addr[2:0] == OFF_ADDR),
      .wr_bank    (hit && reg_addr[2:0] == OFF_BANK),
      .wr_data    (hit && reg_addr[2:0] == OFF_WDATA),
      .issue      (issue_vec[p]),
      .reg_wdata  (reg_wdata),
      .phy_rddata (phy_rddata[p*DATA_W +: DATA_W]),
      .phy_rdvalid(phy_rddata_valid[p]),
      .cmd_q      (cmd_q[p]),
      .addr_q     (addr_q[p]),
      .bank_q     (bank_q[p]),
      .wrdata_q   (wrdata_q[p]),
      .rddata_q   (rddata_q[p]),
      .pulse_q    (pulse_vec[p]),
      .inj_cs_n   (inj_cs_n[p]),
      .inj_we_n   (inj_we_n[p]),
      .inj_cas_n  (inj_cas_n[p]),
      .inj_ras_n  (inj_ras_n[p]),
      .inj_wren   (inj_wren[p]),
      .inj_rden   (inj_rden[p])
    );

    assign inj_address[p*ADDR_W +: ADDR_W] = addr_q[p];
    assign inj_bank[p*BANK_W +: BANK_W]    = bank_q[p];
    assign inj_wrdata[p*DATA_W +: DATA_W]  = wrdata_q[p];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_CTRL) reg_rdata = REG_W'(ctrl_q);
    for (int p = 0; p < NP; p++) begin
      if (reg_addr[REG_AW-1:3] == PHW'(p + 2)) begin
        case (reg_addr[2:0])
          OFF_CMD:   reg_rdata = REG_W'(cmd_q[p]);
          OFF_ADDR:  reg_rdata = REG_W'(addr_q[p]);
          OFF_BANK:  reg_rdata = REG_W'(bank_q[p]);
          OFF_WDATA: reg_rdata = REG_W'(wrdata_q[p]);
          OFF_RDATA: reg_rdata = REG_W'(rddata_q[p]);
          default:   reg_rdata = '0;
        endcase
      end
    end
  end

  dci_mux #(
    .NP(NP), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
  ) u_mux (
    .sel          (ctrl_q[0]),
    .ctrl_pins    (ctrl_q[3:1]),
    .ctl_cs_n     (ctl_cs_n),
    .ctl_we_n     (ctl_we_n),
    .ctl_cas_n    (ctl_cas_n),
    .ctl_ras_n    (ctl_ras_n),
    .ctl_address  (ctl_address),
    .ctl_bank     (ctl_bank),
    .ctl_wrdata   (ctl_wrdata),
    .ctl_wrdata_en(ctl_wrdata_en),
    .ctl_rddata_en(ctl_rddata_en),
    .ctl_cke      (ctl_cke),
    .ctl_odt      (ctl_odt),
    .ctl_reset_n  (ctl_reset_n),
    .inj_cs_n     (inj_cs_n),
    .inj_we_n     (inj_we_n),
    .inj_cas_n    (inj_cas_n),
    .inj_ras_n    (inj_ras_n),
    .inj_address  (inj_address),
    .inj_bank     (inj_bank),
    .inj_wrdata   (inj_wrdata),
    .inj_wrdata_en(inj_wren),
    .inj_rddata_en(inj_rden),
    .dfi_cs_n     (dfi_cs_n),
    .dfi_we_n     (dfi_we_n),
    .dfi_cas_n    (dfi_cas_n),
    .dfi_ras_n    (dfi_ras_n),
    .dfi_address  (dfi_address),
    .dfi_bank     (dfi_bank),
    .dfi_wrdata   (dfi_wrdata),
    .dfi_wrdata_en(dfi_wrdata_en),
    .dfi_rddata_en(dfi_rddata_en),
    .dfi_cke      (dfi_cke),
    .dfi_odt      (dfi_odt),
    .dfi_reset_n  (dfi_reset_n)
  );
endmodule

// File: rtl/dci_checker.sv
module dci_checker #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic [NP-1:0] issue,
  input logic [NP-1:0] pulse,
  input logic [NP-1:0] dfi_cs_n,
  input logic [NP-1:0] dfi_wrdata_en,
  input logic [NP-1:0] dfi_rddata_en
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R4
    cmd_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !dfi_cs_n[p]) |-> $past(issue[p]));

    // R8
    ignored_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && issue[p]) |=> !pulse[p]);

    // R5
    wrdata_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && dfi_wrdata_en[p]) |-> pulse[p]);

    // R6
    rden_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && dfi_rddata_en[p]) |-> pulse[p]);

    // R4
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[p] |-> $past(issue[p]) && !$past(sel));
  end
endmodule

bind dram_cmd_inject dci_checker #(.NP(NP)) u_dci_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel          (ctrl_q[0]),
  .issue        (issue_vec),
  .pulse        (pulse_vec),
  .dfi_cs_n     (dfi_cs_n),
  .dfi_wrdata_en(dfi_wrdata_en),
  .dfi_rddata_en(dfi_rddata_en)
);

// File: tb/dram_cmd_inject_bench.sv
module dram_cmd_inject_bench;
  localparam int NP = 4, AW = 14, BW = 3, DW = 32, RW = 32, RAW = 8;
  localparam int RDP = 2, WRP = 3;

  typedef struct packed {
    logic [7:0]    ph;
    logic [5:0]    cmd;
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    logic [DW-1:0] d;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [RW-1:0]  reg_wdata = '0;
  logic [RW-1:0]  reg_rdata;
  logic [NP-1:0]  ctl_cs_n = '1, ctl_we_n = '1, ctl_cas_n = '1, ctl_ras_n = '1;
  logic [NP*AW-1:0] ctl_address = '0;
  logic [NP*BW-1:0] ctl_bank = '0;
  logic [NP*DW-1:0] ctl_wrdata = '0;
  logic [NP-1:0]  ctl_wrdata_en = '0, ctl_rddata_en = '0;
  logic ctl_cke = 1'b0, ctl_odt = 1'b0, ctl_reset_n = 1'b0;
  logic [NP-1:0]  dfi_cs_n, dfi_we_n, dfi_cas_n, dfi_ras_n;
  logic [NP*AW-1:0] dfi_address;
  logic [NP*BW-1:0] dfi_bank;
  logic [NP*DW-1:0] dfi_wrdata;
  logic [NP-1:0]  dfi_wrdata_en, dfi_rddata_en;
  logic dfi_cke, dfi_odt, dfi_reset_n;
  logic [NP*DW-1:0] phy_rddata = '0;
  logic [NP-1:0]  phy_rddata_valid = '0;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  exp_t expq[$];

  always #2 clk = ~clk;

  dram_cmd_inject #(
    .NP(NP), .ADDR_W(AW), .BANK_W(BW), .DATA_W(DW), .REG_W(RW), .REG_AW(RAW),
    .RD_PHASE(RDP), .WR_PHASE(WRP)
  ) u_dram_cmd_inject (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] pbase(input int p);
    return 8'(16 + 8 * p);
  endfunction

  // load a phase and issue through its own strobe (alias 0) or a global alias
  task automatic inject(input int p, input logic [5:0] c, input logic [AW-1:0] a,
                        input logic [BW-1:0] b, input logic [DW-1:0] d,
                        input int alias_sel, input bit expect_cmd);
    exp_t e;
    wr(pbase(p) + 8'd0, 32'(c));
    wr(pbase(p) + 8'd2, 32'(a));
    wr(pbase(p) + 8'd3, 32'(b));
    wr(pbase(p) + 8'd4, d);
    e.ph = 8'(p); e.cmd = c; e.a = a; e.b = b; e.d = d;
    if (expect_cmd && c != 6'd0) expq.push_back(e);
    if (alias_sel == 1)      wr(8'h01, 32'd1);
    else if (alias_sel == 2) wr(8'h02, 32'd1);
    else                     wr(pbase(p) + 8'd1, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  // monitor: every injected command on any phase must match the next queued item (R3, R4, R5, R6, R9)
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      for (int p = 0; p < NP; p++) begin
        logic busy;
        busy = !dfi_cs_n[p] || !dfi_we_n[p] || !dfi_cas_n[p] || !dfi_ras_n[p]
               || dfi_wrdata_en[p] || dfi_rddata_en[p];
        if (busy) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R4 unexpected command", 64'(p), 64'hff);
          end else begin
            exp_t e, act;
            e = expq.pop_front();
            act.ph  = 8'(p);
            act.cmd = {dfi_rddata_en[p], dfi_wrdata_en[p], ~dfi_ras_n[p],
                       ~dfi_cas_n[p], ~dfi_we_n[p], ~dfi_cs_n[p]};
            act.a   = dfi_address[p*AW +: AW];
            act.b   = dfi_bank[p*BW +: BW];
            act.d   = dfi_wrdata_en[p] ? dfi_wrdata[p*DW +: DW] : e.d;
            chk(act == e, "R3/R5 command contents", 64'(act), 64'(e));
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v);
    chk(v == 0, "R1 control reset", 64'(v), 0);
    chk({dfi_cke, dfi_odt, dfi_reset_n} == 3'b000, "R1 pins", 64'({dfi_cke, dfi_odt, dfi_reset_n}), 0);
    chk(&dfi_cs_n && &dfi_ras_n && !(|dfi_wrdata_en) && !(|dfi_rddata_en), "R1 idle bus",
        64'(dfi_cs_n), 64'hf);
    mon_on = 1'b1;

    // R2 control bits drive pins
    wr(8'h00, 32'b1110);
    chk({dfi_reset_n, dfi_odt, dfi_cke} == 3'b111, "R2 pins 111", 64'({dfi_reset_n, dfi_odt, dfi_cke}), 64'h7);
    wr(8'h00, 32'b1010);
    chk({dfi_reset_n, dfi_odt, dfi_cke} == 3'b101, "R2 pins 101", 64'({dfi_reset_n, dfi_odt, dfi_cke}), 64'h5);

    // R3 R4: several commands on each phase
    inject(0, 6'h09, 14'h1234, 3'd5, 32'h0, 0, 1'b1);
    inject(1, 6'h0B, 14'h0400, 3'd0, 32'h0, 0, 1'b1);
    inject(2, 6'h03, 14'h0ABC, 3'd2, 32'h0, 0, 1'b1);
    inject(3, 6'h01, 14'h3FFF, 3'd7, 32'h0, 0, 1'b1);
    inject(0, 6'h00, 14'h0011, 3'd1, 32'h0, 0, 1'b1);
    // R5 write with data
    inject(1, 6'h17, 14'h0040, 3'd3, 32'hDEADBEEF, 0, 1'b1);
    // R6 read and capture
    inject(1, 6'h25, 14'h0080, 3'd3, 32'h0, 0, 1'b1);
    @(negedge clk); phy_rddata[0*DW +: DW] = 32'h11111111; phy_rddata_valid = 4'b0001;
    @(negedge clk); phy_rddata_valid = '0;
    rd(pbase(1) + 8'd5, v);
    chk(v == 0, "R6 other phase valid ignored", 64'(v), 0);
    @(negedge clk); phy_rddata[1*DW +: DW] = 32'hCAFEF00D; phy_rddata_valid = 4'b0010;
    @(negedge clk); phy_rddata[1*DW +: DW] = 32'h55555555;
    @(negedge clk); phy_rddata_valid = '0;
    rd(pbase(1) + 8'd5, v);
    chk(v == 32'hCAFEF00D, "R6 first valid captured", 64'(v), 64'hCAFEF00D);

    // R9 alias strobes
    inject(RDP, 6'h25, 14'h0101, 3'd4, 32'h0, 1, 1'b1);
    inject(WRP, 6'h17, 14'h0202, 3'd6, 32'hA5A5A5A5, 2, 1'b1);

    // R10 readback
    wr(pbase(2) + 8'd0, 32'h2A);
    rd(pbase(2) + 8'd0, v); chk(v == 32'h2A, "R10 cmd readback", 64'(v), 64'h2A);
    wr(pbase(3) + 8'd2, 32'h1357);
    rd(pbase(3) + 8'd2, v); chk(v == 32'h1357, "R10 address readback", 64'(v), 64'h1357);
    rd(pbase(3) + 8'd3, v); chk(v == 32'd6, "R10 bank readback", 64'(v), 6);
    rd(pbase(3) + 8'd4, v); chk(v == 32'hA5A5A5A5, "R10 wrdata readback", 64'(v), 64'hA5A5A5A5);
    chk(expq.size() == 0, "R3 all commands seen", 64'(expq.size()), 0);

    // R7 controller owns the bus
    mon_on = 1'b0;
    wr(8'h00, 32'b0001);
    @(negedge clk);
    ctl_cs_n = 4'b1010; ctl_we_n = 4'b0110; ctl_cas_n = 4'b0011; ctl_ras_n = 4'b1100;
    ctl_address = {4{14'h2AAA}}; ctl_bank = 12'hABC; ctl_wrdata = {4{32'h01234567}};
    ctl_wrdata_en = 4'b1001; ctl_rddata_en = 4'b0100;
    ctl_cke = 1'b1; ctl_odt = 1'b0; ctl_reset_n = 1'b1;
    #1;
    chk({dfi_cs_n, dfi_we_n, dfi_cas_n, dfi_ras_n} == 16'hA63C, "R7 cmd forwarding",
        64'({dfi_cs_n, dfi_we_n, dfi_cas_n, dfi_ras_n}), 64'hA63C);
    chk(dfi_address == ctl_address && dfi_bank == ctl_bank && dfi_wrdata == ctl_wrdata,
        "R7 operand forwarding", 64'(dfi_bank), 64'(ctl_bank));
    chk({dfi_wrdata_en, dfi_rddata_en, dfi_cke, dfi_odt, dfi_reset_n} == 11'b1001_0100_101,
        "R7 enables and pins", 64'({dfi_wrdata_en, dfi_rddata_en, dfi_cke, dfi_odt, dfi_reset_n}), 64'h4A5);
    @(negedge clk);
    ctl_cs_n = '1; ctl_we_n = '1; ctl_cas_n = '1; ctl_ras_n = '1;
    ctl_wrdata_en = '0; ctl_rddata_en = '0; ctl_cke = 1'b0; ctl_odt = 1'b1; ctl_reset_n = 1'b0;
    #1;
    chk({dfi_cke, dfi_odt, dfi_reset_n} == 3'b010, "R7 pins second pattern",
        64'({dfi_cke, dfi_odt, dfi_reset_n}), 64'h2);

    // R8 strobe while controller owns the bus: no command, no capture armed
    inject(0, 6'h25, 14'h0777, 3'd1, 32'h0, 0, 1'b0);
    chk(&dfi_cs_n && !(|dfi_rddata_en), "R8 no command while owned", 64'(dfi_cs_n), 64'hf);
    @(negedge clk); phy_rddata[0*DW +: DW] = 32'h99999999; phy_rddata_valid = 4'b0001;
    @(negedge clk); phy_rddata_valid = '0;
    wr(8'h00, 32'b0000);
    mon_on = 1'b1;
    rd(pbase(0) + 8'd5, v);
    chk(v == 0, "R8 capture not armed", 64'(v), 0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8 no stray command", 64'(expq.size()), 0);

    done = 1'b1;
    finish_run();
  end
endmodule